// File: doc/BRIEF.md
# Prioritized Machine-Check Error Reporter

This block gathers single-cycle error pulses from a host bridge's memory controller, processor-bus decoder, flash port and PCI side. It ranks them by a fixed priority and tells the processor about the winner. Memory-class errors that arrive while a data tenure is open answer on a one-cycle transfer-error acknowledge. Every other reportable error raises a machine-check request that stays up until cleared. The winning cause is latched as a 3-bit code, and the address that came with it is captured on the same edge. Both stay frozen until software pulses the clear input. Errors that arrive while a cause is already held are dropped.

The block also qualifies the asynchronous hard-reset request. The request passes through a two-flop synchronizer and must hold for a minimum number of cycles; shorter glitches are rejected. While the qualified reset is up, all error state is flushed, the outputs stay inactive and every error input is ignored. A small register that stands for the test-access-port state sits behind its own reset input. Neither the power-on reset nor the hard reset touches it.

Top module: `mc_err_reporter`

## Requirements
- R1: Cause codes: 1 = memory (`mem_err_i` bit 0 select error, bit 1 read parity), 2 = processor bus (`bus_err_i` bit 0 illegal transfer type, bit 1 flash write), 3 = PCI (`pci_err_i` bit 0 address parity, bit 1 data parity, bit 2 master-abort, bit 3 target-abort), 4 = `nmi_i`. When several classes pulse in one cycle, the smallest code wins.
- R2: `cause_o` and `err_addr_o` update on the clock edge that samples the winning pulse. The address comes from the winning class's address input, and it is 0 for code 4.
- R3: While `cause_o` is nonzero, new error pulses change neither `cause_o`, `err_addr_o`, `mcp_o` nor `tea_o`.
- R4: A `clear_i` pulse sets `cause_o`, `err_addr_o` and `mcp_o` to 0 on the next edge. An error in the same cycle as the clear is dropped.
- R5: `mcp_o` rises on the capturing edge for codes 2, 3 and 4, and for code 1 when `data_tenure_i` is low. It then stays high until cleared.
- R6: `tea_o` is high for exactly one cycle, and only when a memory-class error is captured while `data_tenure_i` is high. In that case `mcp_o` stays low.
- R7: `hrst_i` is accepted only if it stays high for at least `MIN_HRST_CYC` consecutive clock samples, after which `sys_rst_o` rises. A pulse one sample shorter never raises `sys_rst_o`. `sys_rst_o` falls within a few cycles after `hrst_i` drops.
- R8: While `sys_rst_o` is high, error state is cleared and held clear: `cause_o` = 0, `mcp_o` = 0, `tea_o` = 0, whatever the error inputs do.
- R9: `tap_q_o` loads `tap_wdata_i` when `tap_we_i` is high. It is cleared only by `tap_rst_ni` and keeps its value through `rst_ni` and through a qualified hard reset.
- R10: While `rst_ni` is low, `cause_o`, `err_addr_o`, `mcp_o`, `tea_o` and `sys_rst_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hrst_i | input | 1 | Asynchronous hard-reset request, active high |
| tap_rst_ni | input | 1 | Dedicated reset of the test-access state, active low |
| tap_we_i | input | 1 | Load strobe for the test-access state |
| tap_wdata_i | input | TAP_W | Value loaded into the test-access state |
| mem_err_i | input | 2 | Memory select / read parity error pulses |
| bus_err_i | input | 2 | Illegal transfer type / flash write error pulses |
| pci_err_i | input | 4 | PCI address parity / data parity / master-abort / target-abort pulses |
| nmi_i | input | 1 | External non-maskable interrupt pulse |
| mem_addr_i | input | ADDR_W | Address accompanying memory errors |
| bus_addr_i | input | ADDR_W | Address accompanying processor-bus errors |
| pci_addr_i | input | ADDR_W | Address accompanying PCI errors |
| data_tenure_i | input | 1 | A processor data tenure is in progress |
| clear_i | input | 1 | Software release of the latched cause |
| mcp_o | output | 1 | Machine-check request |
| tea_o | output | 1 | Transfer-error acknowledge pulse |
| cause_o | output | 3 | Latched cause code, 0 when idle |
| err_addr_o | output | ADDR_W | Captured error address |
| sys_rst_o | output | 1 | Qualified hard reset |
| tap_q_o | output | TAP_W | Test-access state |

## Verification
Several thousand random cycles drive sparse pulses on every error class, together with random clears, data-tenure levels and addresses. Some cycles carry single pulses and some carry coincident ones. Some pulses arrive while a cause is held and some arrive with a clear in the same cycle. These runs separate the priority order, the hold-until-clear rule and the steering between transfer error and machine check. Directed cases stack all classes in one cycle to pin each rung of the ranking. They also send a hard-reset pulse one sample short of the minimum against one that just meets it, which exposes an off-by-one in the width filter. Further directed cases pulse errors while the qualified reset is up, and apply both chip resets around a loaded test-access value to show that value is isolated from them.

// File: rtl/mcerr_pkg.sv
package mcerr_pkg;
  localparam int unsigned NUM_CLASS = 4;
  localparam int unsigned CAUSE_W   = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_MEM  = 3'd1,
    CAUSE_BUS  = 3'd2,
    CAUSE_PCI  = 3'd3,
    CAUSE_NMI  = 3'd4
  } cause_e;
endpackage

// File: rtl/mcerr_hrst_qual.sv
module mcerr_hrst_qual #(
  parameter int unsigned MIN_CYC     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hrst_i,
  output logic hrst_ok_o
);
  localparam int unsigned CNT_W = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   ok_q;
  logic                   hrst_s;

  assign hrst_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], hrst_i};
  end

  // count consecutive synchronized-high samples; qualify on the MIN_CYC-th
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!hrst_s) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (cnt_q == CNT_W'(MIN_CYC - 1)) begin
      ok_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hrst_ok_o = ok_q;

  a_r7_rise_needs_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> $past(hrst_s));
  a_r7_drop_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hrst_s |=> !ok_q);
endmodule

// File: rtl/mcerr_prio.sv
module mcerr_prio #(
  parameter int unsigned NCLS   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 3
) (
  input  logic [NCLS-1:0]             hit_i,
  input  logic [NCLS-1:0][ADDR_W-1:0] addr_i,
  output logic                        win_o,
  output logic [NCLS-1:0]             grant_o,
  output logic [CODE_W-1:0]           code_o,
  output logic [ADDR_W-1:0]           addr_o
);
  logic [NCLS:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCLS; i++) begin : g_rank
    assign seen[i+1]  = seen[i] | hit_i[i];
    assign grant_o[i] = hit_i[i] & ~seen[i];
  end

  assign win_o = seen[NCLS];

  always_comb begin
    code_o = '0;
    addr_o = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (grant_o[i]) begin
        code_o = code_o | CODE_W'(i + 1);
        addr_o = addr_o | addr_i[i];
      end
    end
  end
endmodule

// File: rtl/mcerr_tap_hold.sv
module mcerr_tap_hold #(
  parameter int unsigned TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             tap_rst_ni,
  input  logic             we_i,
  input  logic [TAP_W-1:0] wdata_i,
  output logic [TAP_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge tap_rst_ni) begin
    if (!tap_rst_ni) q_o <= '0;
    else if (we_i)   q_o <= wdata_i;
  end

  a_r9_tap_hold: assert property (@(posedge clk_i) disable iff (!tap_rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/mc_err_reporter.sv
module mc_err_reporter
  import mcerr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned TAP_W        = 8,
  parameter int unsigned MIN_HRST_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hrst_i,
  input  logic               tap_rst_ni,
  input  logic               tap_we_i,
  input  logic [TAP_W-1:0]   tap_wdata_i,
  input  logic [1:0]         mem_err_i,
  input  logic [1:0]         bus_err_i,
  input  logic [3:0]         pci_err_i,
  input  logic               nmi_i,
  input  logic [ADDR_W-1:0]  mem_addr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [ADDR_W-1:0]  pci_addr_i,
  input  logic               data_tenure_i,
  input  logic               clear_i,
  output logic               mcp_o,
  output logic               tea_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ADDR_W-1:0]  err_addr_o,
  output logic               sys_rst_o,
  output logic [TAP_W-1:0]   tap_q_o
);
  localparam int unsigned MEM_IDX = 0;

  logic                             hrst_ok;
  logic [NUM_CLASS-1:0]             hit;
  logic [NUM_CLASS-1:0][ADDR_W-1:0] cls_addr;
  logic [NUM_CLASS-1:0]             grant;
  logic                             win;
  logic [CAUSE_W-1:0]               win_code;
  logic [ADDR_W-1:0]                win_addr;

  cause_e              cause_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                mcp_q;
  logic                tea_q;

  mcerr_hrst_qual #(
    .MIN_CYC     (MIN_HRST_CYC),
    .SYNC_STAGES (2)
  ) u_hrst_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hrst_i    (hrst_i),
    .hrst_ok_o (hrst_ok)
  );

  mcerr_tap_hold #(.TAP_W(TAP_W)) u_tap_hold (
    .clk_i      (clk_i),
    .tap_rst_ni (tap_rst_ni),
    .we_i       (tap_we_i),
    .wdata_i    (tap_wdata_i),
    .q_o        (tap_q_o)
  );

  // class index order is the ranking: lower index wins
  assign hit      = {nmi_i, |pci_err_i, |bus_err_i, |mem_err_i};
  assign cls_addr = {{ADDR_W{1'b0}}, pci_addr_i, bus_addr_i, mem_addr_i};

  mcerr_prio #(
    .NCLS   (NUM_CLASS),
    .ADDR_W (ADDR_W),
    .CODE_W (CAUSE_W)
  ) u_prio (
    .hit_i   (hit),
    .addr_i  (cls_addr),
    .win_o   (win),
    .grant_o (grant),
    .code_o  (win_code),
    .addr_o  (win_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
      mcp_q   <= 1'b0;
      tea_q   <= 1'b0;
    end else if (hrst_ok) begin
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
      mcp_q   <= 1'b0;
      tea_q   <= 1'b0;
    end else begin
      tea_q <= 1'b0;
      if (clear_i) begin
        cause_q <= CAUSE_NONE;
        addr_q  <= '0;
        mcp_q   <= 1'b0;
      end else if (cause_q == CAUSE_NONE && win) begin
        cause_q <= cause_e'(win_code);
        addr_q  <= win_addr;
        if (grant[MEM_IDX] && data_tenure_i) tea_q <= 1'b1;
        else                                 mcp_q <= 1'b1;
      end
    end
  end

  assign mcp_o      = mcp_q;
  assign tea_o      = tea_q;
  assign cause_o    = cause_q;
  assign err_addr_o = addr_q;
  assign sys_rst_o  = hrst_ok;

  a_r6_tea_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_o |=> !tea_o);
  a_r6_tea_mem_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_o |-> (cause_o == CAUSE_MEM) && !mcp_o);
  a_r3_hold_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != CAUSE_NONE && !clear_i && !sys_rst_o)
      |=> $stable(cause_o) && $stable(err_addr_o) && !tea_o);
  a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !sys_rst_o) |=> (cause_o == CAUSE_NONE) && !mcp_o && err_addr_o == '0);
  a_r8_rst_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (cause_o == CAUSE_NONE) && !mcp_o && !tea_o);
  a_r5_mcp_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcp_o |-> cause_o != CAUSE_NONE);
  a_r2_capture_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cause_o) == CAUSE_NONE && cause_o != CAUSE_NONE) |-> $past(|hit));
endmodule

// File: tb/mc_err_reporter_bench.sv
`timescale 1ns/1ps
module mc_err_reporter_bench;
  localparam int unsigned AW  = 16;
  localparam int unsigned TW  = 8;
  localparam int unsigned MIN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, hrst, tap_rst_n, tap_we;
  logic [TW-1:0] tap_wdata;
  logic [1:0]    mem_err, bus_err;
  logic [3:0]    pci_err;
  logic          nmi, tenure, clr;
  logic [AW-1:0] mem_addr, bus_addr, pci_addr;
  logic          mcp, tea, sys_rst;
  logic [2:0]    cause;
  logic [AW-1:0] eaddr;
  logic [TW-1:0] tap_q;

  mc_err_reporter #(.ADDR_W(AW), .TAP_W(TW), .MIN_HRST_CYC(MIN)) u_mc_err_reporter (
    .clk_i(clk), .rst_ni(rst_n), .hrst_i(hrst), .tap_rst_ni(tap_rst_n),
    .tap_we_i(tap_we), .tap_wdata_i(tap_wdata),
    .mem_err_i(mem_err), .bus_err_i(bus_err), .pci_err_i(pci_err), .nmi_i(nmi),
    .mem_addr_i(mem_addr), .bus_addr_i(bus_addr), .pci_addr_i(pci_addr),
    .data_tenure_i(tenure), .clear_i(clr),
    .mcp_o(mcp), .tea_o(tea), .cause_o(cause), .err_addr_o(eaddr),
    .sys_rst_o(sys_rst), .tap_q_o(tap_q)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [2:0]    e_cause;
  logic [AW-1:0] e_addr;
  logic          e_mcp, e_tea;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] f_code(input logic [1:0] m, input logic [1:0] b,
                                        input logic [3:0] p, input logic n);
    if (|m) return 3'd1;
    if (|b) return 3'd2;
    if (|p) return 3'd3;
    if (n)  return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [AW-1:0] f_addr(input logic [2:0] c);
    case (c)
      3'd1: return mem_addr;
      3'd2: return bus_addr;
      3'd3: return pci_addr;
      default: return '0;
    endcase
  endfunction

  task automatic idle_inputs();
    mem_err = '0; bus_err = '0; pci_err = '0; nmi = 0; clr = 0; tenure = 0;
  endtask

  // called at a negedge: drive, model the edge, check at next negedge
  task automatic cycle(input logic [1:0] m, input logic [1:0] b, input logic [3:0] p,
                       input logic n, input logic ten, input logic c);
    logic [2:0] code;
    mem_err = m; bus_err = b; pci_err = p; nmi = n; tenure = ten; clr = c;
    mem_addr = AW'($urandom); bus_addr = AW'($urandom); pci_addr = AW'($urandom);
    code = f_code(m, b, p, n);
    e_tea = 0;
    if (c) begin
      e_cause = 0; e_addr = '0; e_mcp = 0;
    end else if (e_cause == 0 && code != 0) begin
      e_cause = code; e_addr = f_addr(code);
      if (code == 3'd1 && ten) e_tea = 1; else e_mcp = 1;
    end
    @(negedge clk);
    check("R1/R3 cause", 32'(cause), 32'(e_cause));
    check("R2 address", 32'(eaddr), 32'(e_addr));
    check("R5 mcp", 32'(mcp), 32'(e_mcp));
    check("R6 tea", 32'(tea), 32'(e_tea));
  endtask

  task automatic model_clear();
    e_cause = 0; e_addr = '0; e_mcp = 0; e_tea = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic seen;
    void'($urandom(32'd20240611));
    rst_n = 0; tap_rst_n = 0; hrst = 0; tap_we = 0; tap_wdata = '0;
    mem_addr = '0; bus_addr = '0; pci_addr = '0;
    idle_inputs();
    model_clear();
    repeat (3) @(negedge clk);
    // R10 reset state, errors pulsed during reset
    mem_err = 2'b11; nmi = 1;
    @(negedge clk);
    check("R10 cause", 32'(cause), 0);
    check("R10 mcp", 32'(mcp), 0);
    check("R10 tea", 32'(tea), 0);
    check("R10 addr", 32'(eaddr), 0);
    check("R10 sys_rst", 32'(sys_rst), 0);
    idle_inputs();
    rst_n = 1; tap_rst_n = 1;
    @(negedge clk);

    // R1 ranking, all rungs
    cycle(2'b01, 2'b10, 4'b0001, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 2'b01, 4'b1000, 1, 1, 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 4'b0100, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 1, 1, 0);
    check("R2 nmi address zero", 32'(eaddr), 0);
    cycle(0, 0, 0, 0, 0, 1);
    // R6 memory error inside a data tenure, then held (R3)
    cycle(2'b10, 0, 0, 0, 1, 0);
    cycle(2'b01, 2'b01, 0, 1, 1, 0);
    cycle(0, 0, 0, 0, 0, 1);
    // R4 clear and error together
    cycle(2'b01, 0, 4'b0010, 0, 0, 1);
    check("R4 dropped on clear", 32'(cause), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m, b; logic [3:0] p; logic n, ten, c;
      m = 2'($urandom) & {2{$urandom_range(0, 7) == 0}};
      b = 2'($urandom) & {2{$urandom_range(0, 7) == 0}};
      p = 4'($urandom) & {4{$urandom_range(0, 7) == 0}};
      n = ($urandom_range(0, 11) == 0);
      ten = $urandom_range(0, 1) == 1;
      c = ($urandom_range(0, 9) == 0);
      cycle(m, b, p, n, ten, c);
    end
    cycle(0, 0, 0, 0, 0, 1);

    // R9 load test-access state
    tap_we = 1; tap_wdata = 8'hA5;
    @(negedge clk);
    tap_we = 0;
    check("R9 tap load", 32'(tap_q), 32'h A5);

    // R7 glitch one sample short
    hrst = 1;
    repeat (MIN - 1) @(negedge clk);
    hrst = 0;
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    check("R7 short pulse rejected", 32'(seen), 0);

    // latch an error, then qualified hard reset
    cycle(0, 2'b10, 0, 0, 0, 0);
    hrst = 1;
    seen = 0;
    for (int k = 0; k < MIN + 4 && !seen; k++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    check("R7 min pulse accepted", 32'(seen), 1);
    repeat (3) begin
      mem_err = 2'b01; pci_err = 4'b0001; nmi = 1; tenure = 1;
      @(negedge clk);
      check("R8 cause held clear", 32'(cause), 0);
      check("R8 mcp inactive", 32'(mcp), 0);
      check("R8 tea inactive", 32'(tea), 0);
    end
    idle_inputs();
    hrst = 0;
    repeat (6) @(negedge clk);
    check("R7 release", 32'(sys_rst), 0);
    check("R9 tap kept over hard reset", 32'(tap_q), 32'h A5);
    model_clear();

    // R9 power-on reset leaves tap state
    rst_n = 0;
    @(negedge clk);
    check("R10 cleared again", 32'(cause), 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 tap kept over power-on reset", 32'(tap_q), 32'h A5);
    tap_rst_n = 0;
    @(negedge clk);
    check("R9 tap own reset", 32'(tap_q), 0);
    tap_rst_n = 1;

    // normal operation resumes
    cycle(0, 0, 4'b0010, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule